// File: doc/BRIEF.md
# Interrupt Dispatch Protection Checker

This block decides how a single interrupt request is delivered. A request is either raised by an instruction (a one-byte breakpoint form, a two-byte form carrying an immediate vector, or a one-byte overflow form) or by external hardware carrying its own vector. Together with the request, the block receives the processor mode bits and the already-fetched fields of the selected gate entry and of the target code-segment descriptor. Table reads, task switching and stack pushes happen elsewhere; this block only classifies.

One clock after an accepted request, the block raises a single valid strobe. Alongside the strobe it presents either a delivery path (real-address, task gate, same-privilege, privilege-raising, or leaving virtual-8086) or a fault class with a 16-bit error code. The checks run in a fixed order, and only the first failing check is reported. A request that produces no interrupt (overflow form with the overflow flag clear, or an unrecognised opcode) raises no strobe.

Top module: `irq_dispatch_checker`

## Requirements
- R1: Opcode 0xCC yields vector 3 and ignores the immediate byte. Opcode 0xCD yields the immediate byte as vector. A hardware request (req_hw=1) ignores the opcode and uses hw_vector. The vector is shown on out_vector.
- R2: Opcode 0xCE yields vector 4 only when flag_of is 1. With flag_of at 0, or with any opcode other than 0xCC/0xCD/0xCE on an instruction request, no result strobe is produced.
- R3: With mode_pe at 0, the path is real-address (out_path=1, out_fault=0, out_err=0), whatever the gate and segment fields hold.
- R4: With mode_pe=1, mode_vm=1 and iopl below 3, the 0xCD form raises a general-protection fault (out_fault=1) with error code 0. The 0xCC and 0xCE forms and hardware requests are exempt from this check.
- R5: If vector*8+7 exceeds idt_limit, or gate_kind is 0 (not a gate), a general-protection fault is raised with error code vector*8+2+EXT. A limit exactly equal to vector*8+7 passes.
- R6: For an instruction request whose gate_dpl is numerically below cpl, a general-protection fault is raised with error code vector*8+2. Hardware requests skip this check.
- R7: A gate with gate_present=0 raises a not-present fault (out_fault=2) with error code vector*8+2+EXT. A present task gate (gate_kind=1) selects the task path (out_path=2). Interrupt gates (2) and trap gates (3) continue to the segment checks.
- R8: A null target selector (cs_sel_idx=0) raises a general-protection fault with code EXT. A target that is not code, or whose cs_dpl is above cpl, raises a general-protection fault with code {cs_sel_idx,0,EXT}. A target with cs_present=0 raises a not-present fault with that same code.
- R9: For a nonconforming target with cs_dpl below cpl: with mode_vm=0, the path is privilege-raising (out_path=4). With mode_vm=1 and cs_dpl=0, the path is leave-virtual-8086 (out_path=5). With mode_vm=1 and any other cs_dpl, a general-protection fault with the selector code is raised.
- R10: For a conforming target, or a target with cs_dpl equal to cpl, the path is same-privilege (out_path=3). With mode_vm=1 a general-protection fault with the selector code is raised instead.
- R11: Checks are applied in the order real-address, virtual-8086 I/O trap, gate limit/type, gate privilege, gate presence, task selection, null selector, segment type/privilege, segment presence, path choice. Only the first failure is reported.
- R12: out_valid pulses one clock after each accepted req_valid. While it is high, exactly one of out_path and out_fault is nonzero. While it is low, both are 0.
- R13: EXT is 1 for hardware requests and 0 otherwise. It sits in bit 0 of every gate-based and selector-based error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_hw | input | 1 | 1 = hardware-originated request |
| hw_vector | input | 8 | Vector of a hardware request |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 8 | Immediate vector byte of the two-byte form |
| flag_of | input | 1 | Overflow flag |
| mode_pe | input | 1 | Protection enabled |
| mode_vm | input | 1 | Virtual-8086 mode |
| iopl | input | 2 | I/O privilege level |
| cpl | input | 2 | Current privilege level |
| idt_limit | input | 16 | Interrupt table limit in bytes |
| gate_kind | input | 2 | 0 none, 1 task, 2 interrupt, 3 trap |
| gate_dpl | input | 2 | Gate privilege level |
| gate_present | input | 1 | Gate present bit |
| cs_sel_idx | input | 14 | Target selector bits 15:2 (index and table bit) |
| cs_is_code | input | 1 | Target descriptor is a code segment |
| cs_conforming | input | 1 | Target code segment is conforming |
| cs_dpl | input | 2 | Target segment privilege level |
| cs_present | input | 1 | Target segment present bit |
| out_valid | output | 1 | Result strobe |
| out_path | output | 3 | 0 none, 1 real, 2 task, 3 same-priv, 4 raise-priv, 5 leave-v86 |
| out_fault | output | 2 | 0 none, 1 general protection, 2 not present |
| out_err | output | 16 | Fault error code |
| out_vector | output | 8 | Resolved vector |

## Verification
A wrong check order shows at the ports as the wrong fault class or error code. For example, a not-present fault is reported where a privilege fault should win, or a selector code appears where a gate code belongs. Every such error is visible on the strobe one clock after the request. A wrong EXT or vector computation corrupts the low or middle bits of out_err on that same strobe. A lost or spurious strobe, which would come from a broken overflow gate or a broken valid register, is seen by the bench in the cycle it is due.

// File: rtl/irq_chk_pkg.sv
package irq_chk_pkg;

   typedef enum logic [2:0] {
      P_NONE  = 3'd0,
      P_REAL  = 3'd1,
      P_TASK  = 3'd2,
      P_INTRA = 3'd3,
      P_INTER = 3'd4,
      P_V86   = 3'd5
   } path_e;

   typedef enum logic [1:0] {
      F_NONE = 2'd0,
      F_GP   = 2'd1,
      F_NP   = 2'd2
   } fault_e;

   typedef enum logic [1:0] {
      G_NONE = 2'd0,
      G_TASK = 2'd1,
      G_INTR = 2'd2,
      G_TRAP = 2'd3
   } gate_e;

endpackage

// File: rtl/irq_opcode_decode.sv
module irq_opcode_decode #(
   parameter int          VEC_W   = 8,
   parameter logic [7:0]  OPC_BRK = 8'hCC,
   parameter logic [7:0]  OPC_IMM = 8'hCD,
   parameter logic [7:0]  OPC_OVF = 8'hCE,
   parameter int          BRK_VEC = 3,
   parameter int          OVF_VEC = 4
) (
   input  logic             req_hw,
   input  logic [VEC_W-1:0] hw_vector,
   input  logic [7:0]       opcode,
   input  logic [VEC_W-1:0] imm,
   input  logic             flag_of,
   output logic             take,
   output logic             imm_form,
   output logic [VEC_W-1:0] vector
);

   localparam logic [VEC_W-1:0] BRK_V = VEC_W'(BRK_VEC);
   localparam logic [VEC_W-1:0] OVF_V = VEC_W'(OVF_VEC);

   always_comb begin
      take     = 1'b0;
      imm_form = 1'b0;
      vector   = '0;
      if (req_hw) begin
         take   = 1'b1;
         vector = hw_vector;
      end else begin
         unique case (opcode)
            OPC_BRK: begin
               take   = 1'b1;
               vector = BRK_V;
            end
            OPC_IMM: begin
               take     = 1'b1;
               imm_form = 1'b1;
               vector   = imm;
            end
            OPC_OVF: begin
               take   = flag_of;
               vector = OVF_V;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/irq_gate_check.sv
module irq_gate_check
   import irq_chk_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int LIMIT_W = 16,
   parameter int ERR_W   = 16
) (
   input  logic [VEC_W-1:0]   vector,
   input  logic               ext,
   input  logic [LIMIT_W-1:0] idt_limit,
   input  logic [1:0]         gate_kind,
   input  logic [1:0]         gate_dpl,
   input  logic               gate_present,
   input  logic [1:0]         cpl,
   output fault_e             fault,
   output logic [ERR_W-1:0]   err,
   output logic               is_task
);

   localparam int ENTRY_SHIFT = 3;
   localparam int END_W       = VEC_W + ENTRY_SHIFT;

   logic [LIMIT_W-1:0] entry_end;
   logic [ERR_W-1:0]   code_ext;
   logic [ERR_W-1:0]   code_sw;
   logic               bad_place;

   assign entry_end = LIMIT_W'({vector, {ENTRY_SHIFT{1'b1}}});
   assign code_ext  = ERR_W'({vector, 1'b0, 1'b1, ext});
   assign code_sw   = ERR_W'({vector, 1'b0, 1'b1, 1'b0});
   assign bad_place = (entry_end > idt_limit) || (gate_e'(gate_kind) == G_NONE);

   always_comb begin
      fault   = F_NONE;
      err     = '0;
      is_task = 1'b0;
      if (bad_place) begin
         fault = F_GP;
         err   = code_ext;
      end else if (!ext && (gate_dpl < cpl)) begin
         fault = F_GP;
         err   = code_sw;
      end else if (!gate_present) begin
         fault = F_NP;
         err   = code_ext;
      end else begin
         is_task = (gate_e'(gate_kind) == G_TASK);
      end
   end

   if (END_W > LIMIT_W) begin : g_bad_limit_w
      $error("idt limit narrower than a table entry end address");
   end

endmodule

// File: rtl/irq_cseg_check.sv
module irq_cseg_check
   import irq_chk_pkg::*;
#(
   parameter int SEL_W = 16,
   parameter int ERR_W = 16
) (
   input  logic               ext,
   input  logic               mode_vm,
   input  logic [1:0]         cpl,
   input  logic [SEL_W-3:0]   sel_idx,
   input  logic               is_code,
   input  logic               conforming,
   input  logic [1:0]         dpl,
   input  logic               present,
   output path_e              path,
   output fault_e             fault,
   output logic [ERR_W-1:0]   err
);

   logic [ERR_W-1:0] code_sel;
   logic [ERR_W-1:0] code_null;

   assign code_sel  = ERR_W'({sel_idx, 1'b0, ext});
   assign code_null = ERR_W'(ext);

   always_comb begin
      path  = P_NONE;
      fault = F_NONE;
      err   = '0;
      if (sel_idx == '0) begin
         fault = F_GP;
         err   = code_null;
      end else if (!is_code || (dpl > cpl)) begin
         fault = F_GP;
         err   = code_sel;
      end else if (!present) begin
         fault = F_NP;
         err   = code_sel;
      end else if (!conforming && (dpl < cpl)) begin
         if (!mode_vm) begin
            path = P_INTER;
         end else if (dpl == 2'd0) begin
            path = P_V86;
         end else begin
            fault = F_GP;
            err   = code_sel;
         end
      end else if (mode_vm) begin
         fault = F_GP;
         err   = code_sel;
      end else begin
         path = P_INTRA;
      end
   end

   if (ERR_W < SEL_W) begin : g_bad_err_w
      $error("error code narrower than a selector");
   end

endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker
   import irq_chk_pkg::*;
#(
   parameter int         VEC_W   = 8,
   parameter int         LIMIT_W = 16,
   parameter int         SEL_W   = 16,
   parameter int         ERR_W   = 16,
   parameter bit         OUT_REG = 1'b1,
   parameter logic [7:0] OPC_BRK = 8'hCC,
   parameter logic [7:0] OPC_IMM = 8'hCD,
   parameter logic [7:0] OPC_OVF = 8'hCE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_hw,
   input  logic [VEC_W-1:0]   hw_vector,
   input  logic [7:0]         opcode,
   input  logic [VEC_W-1:0]   imm,
   input  logic               flag_of,
   input  logic               mode_pe,
   input  logic               mode_vm,
   input  logic [1:0]         iopl,
   input  logic [1:0]         cpl,
   input  logic [LIMIT_W-1:0] idt_limit,
   input  logic [1:0]         gate_kind,
   input  logic [1:0]         gate_dpl,
   input  logic               gate_present,
   input  logic [SEL_W-3:0]   cs_sel_idx,
   input  logic               cs_is_code,
   input  logic               cs_conforming,
   input  logic [1:0]         cs_dpl,
   input  logic               cs_present,
   output logic               out_valid,
   output logic [2:0]         out_path,
   output logic [1:0]         out_fault,
   output logic [ERR_W-1:0]   out_err,
   output logic [VEC_W-1:0]   out_vector
);

   localparam logic [1:0] IOPL_TOP = 2'd3;

   logic             dec_take;
   logic             dec_imm_form;
   logic [VEC_W-1:0] dec_vector;

   fault_e           gate_fault;
   logic [ERR_W-1:0] gate_err;
   logic             gate_is_task;

   path_e            seg_path;
   fault_e           seg_fault;
   logic [ERR_W-1:0] seg_err;

   logic             nx_valid;
   path_e            nx_path;
   fault_e           nx_fault;
   logic [ERR_W-1:0] nx_err;
   logic             v86_trap;

   irq_opcode_decode #(
      .VEC_W   (VEC_W),
      .OPC_BRK (OPC_BRK),
      .OPC_IMM (OPC_IMM),
      .OPC_OVF (OPC_OVF)
   ) u_decode (
      .req_hw    (req_hw),
      .hw_vector (hw_vector),
      .opcode    (opcode),
      .imm       (imm),
      .flag_of   (flag_of),
      .take      (dec_take),
      .imm_form  (dec_imm_form),
      .vector    (dec_vector)
   );

   irq_gate_check #(
      .VEC_W   (VEC_W),
      .LIMIT_W (LIMIT_W),
      .ERR_W   (ERR_W)
   ) u_gate (
      .vector       (dec_vector),
      .ext          (req_hw),
      .idt_limit    (idt_limit),
      .gate_kind    (gate_kind),
      .gate_dpl     (gate_dpl),
      .gate_present (gate_present),
      .cpl          (cpl),
      .fault        (gate_fault),
      .err          (gate_err),
      .is_task      (gate_is_task)
   );

   irq_cseg_check #(
      .SEL_W (SEL_W),
      .ERR_W (ERR_W)
   ) u_cseg (
      .ext        (req_hw),
      .mode_vm    (mode_vm),
      .cpl        (cpl),
      .sel_idx    (cs_sel_idx),
      .is_code    (cs_is_code),
      .conforming (cs_conforming),
      .dpl        (cs_dpl),
      .present    (cs_present),
      .path       (seg_path),
      .fault      (seg_fault),
      .err        (seg_err)
   );

   assign v86_trap = mode_vm && (iopl != IOPL_TOP) && dec_imm_form;

   // ordered selection: the first failing stage wins
   always_comb begin
      nx_valid = req_valid && dec_take;
      nx_path  = P_NONE;
      nx_fault = F_NONE;
      nx_err   = '0;
      if (nx_valid) begin
         if (!mode_pe) begin
            nx_path = P_REAL;
         end else if (v86_trap) begin
            nx_fault = F_GP;
         end else if (gate_fault != F_NONE) begin
            nx_fault = gate_fault;
            nx_err   = gate_err;
         end else if (gate_is_task) begin
            nx_path = P_TASK;
         end else begin
            nx_path  = seg_path;
            nx_fault = seg_fault;
            nx_err   = seg_err;
         end
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            out_path   <= P_NONE;
            out_fault  <= F_NONE;
            out_err    <= '0;
            out_vector <= '0;
         end else begin
            out_valid  <= nx_valid;
            out_path   <= nx_path;
            out_fault  <= nx_fault;
            out_err    <= nx_err;
            out_vector <= nx_valid ? dec_vector : '0;
         end
      end

      AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ((out_path != 3'(P_NONE)) != (out_fault != 2'(F_NONE)))); // R12
      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> (out_path == 3'(P_NONE) && out_fault == 2'(F_NONE))); // R12
      AST_STROBE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $past(req_valid)); // R12
      AST_REAL_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !$past(mode_pe)) |-> out_path == 3'(P_REAL)); // R3
      AST_V86_IMM_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
         $past(req_valid && !req_hw && opcode == OPC_IMM && mode_pe && mode_vm && iopl != IOPL_TOP)
         |-> (out_valid && out_fault == 2'(F_GP) && out_err == '0)); // R4
      AST_OVF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         $past(req_valid && !req_hw && opcode == OPC_OVF && !flag_of) |-> !out_valid); // R2
      AST_EXT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_fault != 2'(F_NONE) && $past(req_hw)) |-> out_err[0]); // R13
      AST_V86_NO_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(mode_pe && mode_vm))
         |-> (out_path != 3'(P_INTRA) && out_path != 3'(P_INTER))); // R10
   end else begin : g_comb
      assign out_valid  = nx_valid;
      assign out_path   = nx_path;
      assign out_fault  = nx_fault;
      assign out_err    = nx_err;
      assign out_vector = nx_valid ? dec_vector : '0;
   end

   if (SEL_W != ERR_W) begin : g_bad_width
      $error("selector and error code widths must match");
   end
   if (VEC_W != 8) begin : g_bad_vec
      $error("opcode immediate carries an 8-bit vector");
   end

endmodule

// File: tb/irq_dispatch_checker_test.sv
`timescale 1ns/1ps
module irq_dispatch_checker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_hw = 0, flag_of = 0, mode_pe = 0, mode_vm = 0;
   logic [7:0]  hw_vector = 0, opcode = 0, imm = 0;
   logic [1:0]  iopl = 0, cpl = 0, gate_kind = 0, gate_dpl = 0, cs_dpl = 0;
   logic [15:0] idt_limit = 0;
   logic        gate_present = 0, cs_is_code = 0, cs_conforming = 0, cs_present = 0;
   logic [13:0] cs_sel_idx = 0;
   logic        out_valid;
   logic [2:0]  out_path;
   logic [1:0]  out_fault;
   logic [15:0] out_err;
   logic [7:0]  out_vector;

   typedef struct {
      int          due;
      bit          v;
      logic [2:0]  path;
      logic [1:0]  fault;
      logic [15:0] err;
      logic [7:0]  vec;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   done = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   irq_dispatch_checker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hw(req_hw),
      .hw_vector(hw_vector), .opcode(opcode), .imm(imm), .flag_of(flag_of),
      .mode_pe(mode_pe), .mode_vm(mode_vm), .iopl(iopl), .cpl(cpl),
      .idt_limit(idt_limit), .gate_kind(gate_kind), .gate_dpl(gate_dpl),
      .gate_present(gate_present), .cs_sel_idx(cs_sel_idx), .cs_is_code(cs_is_code),
      .cs_conforming(cs_conforming), .cs_dpl(cs_dpl), .cs_present(cs_present),
      .out_valid(out_valid), .out_path(out_path), .out_fault(out_fault),
      .out_err(out_err), .out_vector(out_vector)
   );

   // monitor: compares due items at each falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit matched;
         matched = 0;
         while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            matched = 1;
            checks++;
            if (!e.v) begin
               if (out_valid !== 1'b0) begin
                  fails++;
                  $display("FAIL %s: strobe=%0b expected=0", e.tag, out_valid);
               end
            end else if (out_valid !== 1'b1 || out_path !== e.path || out_fault !== e.fault ||
                         out_err !== e.err || out_vector !== e.vec) begin
               fails++;
               $display("FAIL %s: v=%0b path=%0d fault=%0d err=%h vec=%h expected v=1 path=%0d fault=%0d err=%h vec=%h",
                        e.tag, out_valid, out_path, out_fault, out_err, out_vector,
                        e.path, e.fault, e.err, e.vec);
            end
         end
         if (!matched && out_valid === 1'b1) begin
            checks++;
            fails++;
            $display("FAIL R12 spurious strobe: v=1 expected v=0");
         end
      end
   end

   task automatic base_sw();
      req_hw = 0; hw_vector = 8'h21; opcode = 8'hCD; imm = 8'h21; flag_of = 0;
      mode_pe = 1; mode_vm = 0; iopl = 0; cpl = 3;
      idt_limit = 16'h07FF; gate_kind = 2'd2; gate_dpl = 3; gate_present = 1;
      cs_sel_idx = 14'h0004; cs_is_code = 1; cs_conforming = 0; cs_dpl = 0; cs_present = 1;
   endtask

   task automatic base_hw();
      base_sw();
      req_hw = 1; opcode = 8'h00; imm = 8'h00;
   endtask

   task automatic send(bit v, logic [2:0] p, logic [1:0] f, logic [15:0] er,
                       logic [7:0] vc, string tag);
      exp_t e;
      e.due = cyc + 1; e.v = v; e.path = p; e.fault = f; e.err = er; e.vec = vc; e.tag = tag;
      q.push_back(e);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 0 || out_path !== 0 || out_fault !== 0 || out_err !== 0) begin
         fails++;
         $display("FAIL R12 reset: v=%0b path=%0d fault=%0d err=%h expected all 0",
                  out_valid, out_path, out_fault, out_err);
      end
      rst_n = 1;
      @(negedge clk);

      base_sw(); send(1, 4, 0, 16'h0, 8'h21, "R1 R9 imm form raise-priv");
      base_sw(); opcode = 8'hCC; imm = 8'h55; send(1, 4, 0, 16'h0, 8'h03, "R1 breakpoint vector");
      base_sw(); opcode = 8'hCE; flag_of = 1; send(1, 4, 0, 16'h0, 8'h04, "R2 overflow taken");
      base_sw(); opcode = 8'hCE; flag_of = 0; send(0, 0, 0, 0, 0, "R2 overflow clear");
      base_sw(); opcode = 8'h90; send(0, 0, 0, 0, 0, "R2 other opcode");
      base_hw(); opcode = 8'hCE; send(1, 4, 0, 16'h0, 8'h21, "R1 hw ignores opcode");
      base_sw(); mode_pe = 0; gate_kind = 0; send(1, 1, 0, 16'h0, 8'h21, "R3 real path");
      base_hw(); mode_pe = 0; cs_sel_idx = 0; send(1, 1, 0, 16'h0, 8'h21, "R3 real hw");
      base_sw(); mode_vm = 1; iopl = 2; send(1, 0, 1, 16'h0, 8'h21, "R4 v86 trap");
      base_sw(); mode_vm = 1; iopl = 2; opcode = 8'hCC; send(1, 5, 0, 16'h0, 8'h03, "R4 breakpoint exempt");
      base_sw(); mode_vm = 1; iopl = 2; opcode = 8'hCE; flag_of = 1; send(1, 5, 0, 16'h0, 8'h04, "R4 overflow exempt");
      base_hw(); mode_vm = 1; iopl = 0; send(1, 5, 0, 16'h0, 8'h21, "R4 hw exempt");
      base_sw(); mode_vm = 1; iopl = 3; send(1, 5, 0, 16'h0, 8'h21, "R9 leave v86");
      base_sw(); idt_limit = 16'h010E; send(1, 0, 1, 16'h010A, 8'h21, "R5 over limit");
      base_sw(); idt_limit = 16'h010F; send(1, 4, 0, 16'h0, 8'h21, "R5 limit exact");
      base_sw(); gate_kind = 0; send(1, 0, 1, 16'h010A, 8'h21, "R5 not a gate");
      base_hw(); idt_limit = 16'h010E; send(1, 0, 1, 16'h010B, 8'h21, "R5 R13 hw over limit");
      base_sw(); gate_dpl = 2; send(1, 0, 1, 16'h010A, 8'h21, "R6 gate priv");
      base_hw(); gate_dpl = 2; send(1, 4, 0, 16'h0, 8'h21, "R6 hw skips gate priv");
      base_sw(); gate_present = 0; send(1, 0, 2, 16'h010A, 8'h21, "R7 gate absent");
      base_hw(); gate_present = 0; send(1, 0, 2, 16'h010B, 8'h21, "R7 R13 hw gate absent");
      base_sw(); gate_kind = 1; cs_sel_idx = 0; send(1, 2, 0, 16'h0, 8'h21, "R7 task gate");
      base_sw(); gate_kind = 3; send(1, 4, 0, 16'h0, 8'h21, "R7 trap gate continues");
      base_sw(); gate_kind = 1; gate_present = 0; send(1, 0, 2, 16'h010A, 8'h21, "R7 task gate absent");
      base_sw(); cs_sel_idx = 0; send(1, 0, 1, 16'h0000, 8'h21, "R8 null selector");
      base_hw(); cs_sel_idx = 0; send(1, 0, 1, 16'h0001, 8'h21, "R8 R13 hw null selector");
      base_sw(); cs_is_code = 0; send(1, 0, 1, 16'h0010, 8'h21, "R8 not code");
      base_hw(); cs_is_code = 0; send(1, 0, 1, 16'h0011, 8'h21, "R8 R13 hw not code");
      base_sw(); cpl = 0; gate_dpl = 3; cs_dpl = 1; send(1, 0, 1, 16'h0010, 8'h21, "R8 target above cpl");
      base_sw(); cs_present = 0; send(1, 0, 2, 16'h0010, 8'h21, "R8 segment absent");
      base_sw(); mode_vm = 1; iopl = 3; cs_dpl = 1; send(1, 0, 1, 16'h0010, 8'h21, "R9 v86 nonzero target");
      base_sw(); cs_dpl = 3; send(1, 3, 0, 16'h0, 8'h21, "R10 same level");
      base_sw(); cs_conforming = 1; send(1, 3, 0, 16'h0, 8'h21, "R10 conforming");
      base_sw(); mode_vm = 1; iopl = 3; cs_conforming = 1; send(1, 0, 1, 16'h0010, 8'h21, "R10 v86 conforming");
      base_sw(); gate_dpl = 2; gate_present = 0; send(1, 0, 1, 16'h010A, 8'h21, "R11 priv before presence");
      base_sw(); gate_present = 0; cs_sel_idx = 0; send(1, 0, 2, 16'h010A, 8'h21, "R11 gate before segment");
      base_sw(); mode_vm = 1; iopl = 1; idt_limit = 0; send(1, 0, 1, 16'h0000, 8'h21, "R11 v86 trap first");
      base_sw(); cs_is_code = 0; cs_present = 0; send(1, 0, 1, 16'h0010, 8'h21, "R11 type before presence");

      repeat (4) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R12 pending results: left=%0d expected=0", q.size());
      end
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule